// File: doc/BRIEF.md
# Fetch Request Retry Controller

This block sits between an instruction fetch stage and an instruction memory port. For each fetch it issues a single read for the whole 64-byte line holding the fetch PC. The port may refuse that read. When it does, the controller keeps the read in a one-entry holding slot and marks the port as blocked. It sends the read again only when the port pulses a retry strobe. Once the port accepts a read, the controller waits for the response and then reports through a one-cycle line-valid pulse that the line data can be used.

Every read carries a tag that is allocated in increasing order. A response is taken only while the controller is waiting for one and only if its tag matches the read that is outstanding. Any other response counts as the answer to a squashed fetch and is thrown away. A squash input cancels whatever the controller is doing: an outstanding read, a held read, or a completed access that has not yet been reported. The blocked flag stays set after a squash, and only the next retry strobe clears it. Two free-running counters expose the cycles spent stalled and the number of responses dropped.

Top module: `fetch_retry_ctrl`

## Requirements
- R1: After reset, req_valid, line_valid and port_blocked are low, and stall_cnt and drop_cnt are zero.
- R2: When fetch_go is high, the controller is idle, the port is not blocked and squash is low, req_valid is high in that same cycle. req_addr is fetch_pc with its low six bits cleared. req_tag equals the number of earlier new requests modulo 2^TAG_W, starting from 0. A resend does not consume a tag.
- R3: If req_ready is low while a new request is presented, port_blocked is high from the next cycle and the request is held. No request is presented again until a retry strobe arrives.
- R4: While port_blocked is high, fetch_go has no effect: req_valid stays low and port_blocked stays high.
- R5: A retry_i pulse while a request is held presents that request again in the same cycle, with the held address and tag. If req_ready is high in that cycle, port_blocked is low from the next cycle and the controller waits for the response. If req_ready is low, the request stays held and port_blocked stays high.
- R6: A response is accepted only while the controller is waiting for a response, its rsp_tag matches the outstanding request's tag, and squash is low. line_valid is then high for exactly one cycle, the second cycle after the one in which the response was presented.
- R7: Every rsp_valid cycle that is not accepted raises drop_cnt by one and produces no line_valid pulse.
- R8: A squash while waiting for a response cancels the outstanding request. A later response carrying its tag is dropped.
- R9: A squash while a request is held discards that request but leaves port_blocked high. The next retry_i presents nothing and only clears port_blocked.
- R10: A squash in the cycle after a response has been accepted suppresses the line_valid pulse.
- R11: stall_cnt rises by one at every clock edge at which the controller is waiting for a response or for a retry, and holds its value otherwise.
- R12: squash held high in the same cycle as fetch_go suppresses the new request: req_valid stays low and no tag is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_go | input | 1 | Request a line read for fetch_pc |
| fetch_pc | input | ADDR_W | Fetch program counter |
| squash | input | 1 | Cancel the in-flight fetch |
| req_valid | output | 1 | Read request presented to the memory port |
| req_ready | input | 1 | Memory port accepts the request this cycle |
| req_addr | output | ADDR_W | Line-aligned read address |
| req_tag | output | TAG_W | Tag of the presented request |
| retry_i | input | 1 | Strobe from the port: a refused request may be sent again |
| rsp_valid | input | 1 | Response present |
| rsp_tag | input | TAG_W | Tag carried by the response |
| line_valid | output | 1 | One-cycle pulse: fetched line data is valid |
| port_blocked | output | 1 | Port refused a request and no retry has been seen yet |
| stall_cnt | output | CNT_W | Cycles spent in either wait state |
| drop_cnt | output | CNT_W | Responses that were discarded |

## Verification
The bench builds the block with TAG_W set to 3 and CNT_W set to 8, keeping a 32-bit address and 64-byte lines. With a 3-bit tag the run issues enough requests to wrap the tag from 7 back to 0, and a scoreboard checks every accepted address and tag against that wrap. The narrow counters keep the expected stall and drop counts easy to compare. The scenarios cover refusal followed by a refused and then an accepted retry, squash in every state, responses with stale or wrong tags, and an unaligned PC whose low bits are all ones.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_WAIT_RSP   = 2'd1,
    ST_WAIT_RETRY = 2'd2,
    ST_DONE       = 2'd3
  } frc_state_e;
endpackage

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (inc) count_d = count + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/frc_tag_alloc.sv
module frc_tag_alloc #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic [TAG_W-1:0] tag
);
  logic [TAG_W-1:0] tag_d;

  always_comb begin
    tag_d = tag;
    if (take) tag_d = tag + TAG_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag <= '0;
    else        tag <= tag_d;
  end
endmodule

// File: rtl/frc_park_slot.sv
module frc_park_slot #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic              clear,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag
);
  logic              valid_d;
  logic [ADDR_W-1:0] addr_d;
  logic [TAG_W-1:0]  tag_d;

  always_comb begin
    valid_d = valid;
    addr_d  = addr;
    tag_d   = tag;
    if (clear) valid_d = 1'b0;
    if (load) begin
      valid_d = 1'b1;
      addr_d  = load_addr;
      tag_d   = load_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      tag   <= '0;
    end else begin
      valid <= valid_d;
      addr  <= addr_d;
      tag   <= tag_d;
    end
  end
endmodule

// File: rtl/fetch_retry_ctrl.sv
module fetch_retry_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int TAG_W      = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_go,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              squash,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              retry_i,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  output logic              line_valid,
  output logic              port_blocked,
  output logic [CNT_W-1:0]  stall_cnt,
  output logic [CNT_W-1:0]  drop_cnt
);
  import frc_pkg::*;

  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  frc_state_e       state_q, state_d;
  logic             blocked_q, blocked_d;
  logic             lv_q, lv_d;
  logic [TAG_W-1:0] outs_tag_q, outs_tag_d;

  logic              park_valid;
  logic [ADDR_W-1:0] park_addr;
  logic [TAG_W-1:0]  park_tag;
  logic [TAG_W-1:0]  new_tag;

  logic issue_new, resend, sent, rsp_hit, rsp_drop, in_wait;
  logic park_load, park_clear;

  // request presentation
  always_comb begin
    issue_new  = (state_q == ST_RUN) && fetch_go && !blocked_q && !squash;
    resend     = (state_q == ST_WAIT_RETRY) && retry_i && park_valid && !squash;
    req_valid  = issue_new || resend;
    req_addr   = resend ? park_addr : (fetch_pc & LINE_MASK);
    req_tag    = resend ? park_tag  : new_tag;
    sent       = req_valid && req_ready;
    rsp_hit    = rsp_valid && (state_q == ST_WAIT_RSP) &&
                 (rsp_tag == outs_tag_q) && !squash;
    rsp_drop   = rsp_valid && !rsp_hit;
    in_wait    = (state_q == ST_WAIT_RSP) || (state_q == ST_WAIT_RETRY);
    park_load  = issue_new && !req_ready;
    park_clear = (resend && req_ready) || squash;
  end

  // next state
  always_comb begin
    state_d    = state_q;
    blocked_d  = blocked_q;
    outs_tag_d = outs_tag_q;
    lv_d       = 1'b0;

    if (sent) outs_tag_d = req_tag;

    if (park_load)                    blocked_d = 1'b1;
    if (resend && req_ready)          blocked_d = 1'b0;
    if (retry_i && !park_valid)       blocked_d = 1'b0;

    if (squash) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (issue_new) state_d = req_ready ? ST_WAIT_RSP : ST_WAIT_RETRY;
        end
        ST_WAIT_RSP: begin
          if (rsp_hit) state_d = ST_DONE;
        end
        ST_WAIT_RETRY: begin
          if (resend && req_ready) state_d = ST_WAIT_RSP;
        end
        ST_DONE: begin
          lv_d    = 1'b1;
          state_d = ST_RUN;
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q    <= ST_RUN;
      blocked_q  <= 1'b0;
      lv_q       <= 1'b0;
      outs_tag_q <= '0;
    end else begin
      state_q    <= state_d;
      blocked_q  <= blocked_d;
      lv_q       <= lv_d;
      outs_tag_q <= outs_tag_d;
    end
  end

  assign line_valid   = lv_q;
  assign port_blocked = blocked_q;

  frc_tag_alloc #(.TAG_W(TAG_W)) u_tag (
    .clk   (clk),
    .rst_n (rst_n_i),
    .take  (issue_new),
    .tag   (new_tag)
  );

  frc_park_slot #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_park (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (park_load),
    .load_addr (req_addr),
    .load_tag  (req_tag),
    .clear     (park_clear),
    .valid     (park_valid),
    .addr      (park_addr),
    .tag       (park_tag)
  );

  frc_counter #(.W(CNT_W)) u_stall (
    .clk   (clk),
    .rst_n (rst_n_i),
    .inc   (in_wait),
    .count (stall_cnt)
  );

  frc_counter #(.W(CNT_W)) u_drop (
    .clk   (clk),
    .rst_n (rst_n_i),
    .inc   (rsp_drop),
    .count (drop_cnt)
  );

  // R3
  refuse_block_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && !req_ready && state_q == ST_RUN) |=> (port_blocked && state_q == ST_WAIT_RETRY));

  // R3
  wait_retry_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == ST_WAIT_RETRY) |-> port_blocked);

  // R4
  blocked_no_new_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (port_blocked && state_q == ST_RUN) |-> !req_valid);

  // R6
  line_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    line_valid |-> ($past(state_q) == ST_DONE && !$past(squash)));

  // R6
  line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    line_valid |=> !line_valid);

  // R11
  stall_count_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    in_wait |=> (stall_cnt == $past(stall_cnt) + CNT_W'(1)));

  // R12
  squash_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    squash |-> !req_valid);
endmodule

// File: tb/fetch_retry_ctrl_tb.sv
module fetch_retry_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int TAG_W      = 3;
  localparam int CNT_W      = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              fetch_go;
  logic [ADDR_W-1:0] fetch_pc;
  logic              squash;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [TAG_W-1:0]  req_tag;
  logic              retry_i;
  logic              rsp_valid;
  logic [TAG_W-1:0]  rsp_tag;
  logic              line_valid;
  logic              port_blocked;
  logic [CNT_W-1:0]  stall_cnt;
  logic [CNT_W-1:0]  drop_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_retry_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(64), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .fetch_pc(fetch_pc), .squash(squash),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_tag(req_tag),
    .retry_i(retry_i), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .line_valid(line_valid),
    .port_blocked(port_blocked), .stall_cnt(stall_cnt), .drop_cnt(drop_cnt)
  );

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
  } exp_req_t;

  exp_req_t exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  int exp_tag  = 0;
  int exp_drop = 0;
  bit done     = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor: every accepted request must match the queue head (R2, R5)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req_valid && req_ready) begin
        if (exp_q.size() == 0) begin
          chk("R2", "unexpected accepted request", 64'(req_addr), 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          exp_req_t e;
          e = exp_q.pop_front();
          chk("R5", "accepted addr", 64'(req_addr), 64'(e.addr));
          chk("R5", "accepted tag", 64'(req_tag), 64'(e.tag));
        end
      end
    end
  end

  // present a new fetch; checks R2 in the same cycle
  task automatic do_fetch(input logic [ADDR_W-1:0] pc, input logic ready);
    exp_req_t e;
    fetch_go  = 1'b1;
    fetch_pc  = pc;
    req_ready = ready;
    #1;
    chk("R2", "req_valid", 64'(req_valid), 64'd1);
    chk("R2", "req_addr aligned", 64'(req_addr), 64'(pc & ~32'h3F));
    chk("R2", "req_tag", 64'(req_tag), 64'(exp_tag % (1 << TAG_W)));
    if (ready) begin
      e.addr = pc & ~32'h3F;
      e.tag  = TAG_W'(exp_tag % (1 << TAG_W));
      exp_q.push_back(e);
    end
    exp_tag++;
    step();
    fetch_go  = 1'b0;
    req_ready = 1'b0;
  endtask

  task automatic send_rsp(input int t);
    rsp_valid = 1'b1;
    rsp_tag   = TAG_W'(t);
    step();
    rsp_valid = 1'b0;
  endtask

  // response accepted: line_valid pulse on the second cycle (R6)
  task automatic expect_line();
    chk("R6", "line_valid during complete", 64'(line_valid), 64'd0);
    step();
    chk("R6", "line_valid pulse", 64'(line_valid), 64'd1);
    step();
    chk("R6", "line_valid one cycle", 64'(line_valid), 64'd0);
  endtask

  task automatic expect_no_line(input string req);
    chk(req, "no line_valid", 64'(line_valid), 64'd0);
    step();
    chk(req, "no line_valid", 64'(line_valid), 64'd0);
    step();
    chk(req, "no line_valid", 64'(line_valid), 64'd0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [CNT_W-1:0] s;
    rst_n = 1'b0; fetch_go = 1'b0; fetch_pc = '0; squash = 1'b0;
    req_ready = 1'b0; retry_i = 1'b0; rsp_valid = 1'b0; rsp_tag = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1", "req_valid", 64'(req_valid), 64'd0);
    chk("R1", "line_valid", 64'(line_valid), 64'd0);
    chk("R1", "port_blocked", 64'(port_blocked), 64'd0);
    chk("R1", "stall_cnt", 64'(stall_cnt), 64'd0);
    chk("R1", "drop_cnt", 64'(drop_cnt), 64'd0);

    // accepted fetch, stall counting, wrong tag, correct tag
    do_fetch(32'h1234_5678, 1'b1);
    s = stall_cnt;
    repeat (3) step();
    chk("R11", "stall_cnt in wait", 64'(stall_cnt), 64'(s + CNT_W'(3)));
    send_rsp(5);
    exp_drop++;
    chk("R7", "drop_cnt wrong tag", 64'(drop_cnt), 64'(exp_drop));
    chk("R7", "no line on wrong tag", 64'(line_valid), 64'd0);
    send_rsp(0);
    expect_line();
    s = stall_cnt;
    repeat (2) step();
    chk("R11", "stall_cnt idle", 64'(stall_cnt), 64'(s));
    send_rsp(0);
    exp_drop++;
    chk("R7", "drop_cnt stale in run", 64'(drop_cnt), 64'(exp_drop));
    expect_no_line("R7");

    // refusal, blocked fetch, refused retry, accepted retry
    do_fetch(32'h0000_10FF, 1'b0);
    chk("R3", "port_blocked", 64'(port_blocked), 64'd1);
    step();
    chk("R3", "no request without retry", 64'(req_valid), 64'd0);
    fetch_go = 1'b1; fetch_pc = 32'h0000_5000; req_ready = 1'b1;
    #1;
    chk("R4", "fetch_go ignored when blocked", 64'(req_valid), 64'd0);
    step();
    fetch_go = 1'b0; req_ready = 1'b0;
    chk("R4", "still blocked", 64'(port_blocked), 64'd1);
    retry_i = 1'b1;
    #1;
    chk("R5", "resend valid", 64'(req_valid), 64'd1);
    chk("R5", "resend addr", 64'(req_addr), 64'h10C0);
    chk("R5", "resend tag", 64'(req_tag), 64'd1);
    step();
    retry_i = 1'b0;
    chk("R5", "blocked after refused retry", 64'(port_blocked), 64'd1);
    step();
    begin
      exp_req_t e;
      e.addr = 32'h10C0; e.tag = 3'd1;
      exp_q.push_back(e);
    end
    retry_i = 1'b1; req_ready = 1'b1;
    #1;
    chk("R5", "resend valid accepted", 64'(req_valid), 64'd1);
    step();
    retry_i = 1'b0; req_ready = 1'b0;
    chk("R5", "blocked cleared", 64'(port_blocked), 64'd0);
    send_rsp(1);
    expect_line();

    // squash while waiting for response
    do_fetch(32'h0000_2000, 1'b1);
    squash = 1'b1;
    step();
    squash = 1'b0;
    send_rsp(2);
    exp_drop++;
    chk("R8", "drop_cnt after squash", 64'(drop_cnt), 64'(exp_drop));
    expect_no_line("R8");

    // squash while held
    do_fetch(32'h0000_3040, 1'b0);
    squash = 1'b1;
    step();
    squash = 1'b0;
    chk("R9", "blocked kept after squash", 64'(port_blocked), 64'd1);
    retry_i = 1'b1; req_ready = 1'b1;
    #1;
    chk("R9", "no resend after squash", 64'(req_valid), 64'd0);
    step();
    retry_i = 1'b0; req_ready = 1'b0;
    chk("R9", "blocked cleared by retry", 64'(port_blocked), 64'd0);

    // squash after acceptance suppresses line_valid
    do_fetch(32'h0000_4444, 1'b1);
    send_rsp(4);
    squash = 1'b1;
    step();
    squash = 1'b0;
    chk("R10", "no line after squash", 64'(line_valid), 64'd0);
    step();
    chk("R10", "no line after squash", 64'(line_valid), 64'd0);

    // squash together with fetch_go
    fetch_go = 1'b1; fetch_pc = 32'h0000_6000; squash = 1'b1; req_ready = 1'b1;
    #1;
    chk("R12", "req suppressed by squash", 64'(req_valid), 64'd0);
    step();
    fetch_go = 1'b0; squash = 1'b0; req_ready = 1'b0;

    // tag sequence and wrap, unaligned PCs
    for (int i = 0; i < 6; i++) begin
      int t;
      t = exp_tag % (1 << TAG_W);
      do_fetch(32'h0001_0000 + 32'(i * 64) + 32'h3F, 1'b1);
      send_rsp(t);
      expect_line();
    end

    chk("R2", "scoreboard drained", 64'(exp_q.size()), 64'd0);
    chk("R7", "final drop_cnt", 64'(drop_cnt), 64'(exp_drop));
    done = 1'b1;
    summary();
  end
endmodule